// File: doc/BRIEF.md
# Posted-Write Display Memory Arbiter

This block shares one display memory between two requesters. The video refresh requester always comes first, and a CPU port gets the memory only in cycles that refresh does not claim. Refresh owns the memory port in any cycle in which it asks for it. The CPU side has a one-entry posted-write buffer. A CPU write that finds the buffer empty is captured at once and acknowledged in the same cycle. It is then written to memory in the first cycle that refresh leaves free.

A CPU read cannot be posted. It waits until the buffer has drained and a free cycle comes up. The read is then issued, and ready is raised in the cycle after the issue, together with the data returned by the memory. The memory is assumed to be synchronous, with a read latency of one cycle. The CPU holds its request and its fields stable until it sees ready.

Top module: `pw_mem_arbiter`

## Requirements
- R1: In every cycle with `rfsh_req` high, `rfsh_grant` is high, `mem_en` is high, `mem_we` is low and `mem_addr` equals `rfsh_addr`, whatever the CPU side is doing.
- R2: A CPU write (`cpu_req`=1, `cpu_we`=1) that finds the buffer empty gets `cpu_ready`=1 in that same cycle, with no memory access in that cycle.
- R3: A buffered write is retired in the first cycle after capture with `rfsh_req` low. In that cycle `mem_en`=1, `mem_we`=1, and `mem_addr`/`mem_wdata` carry the captured address and data.
- R4: A CPU write issued while a buffered write is pending sees `cpu_ready`=0. It is accepted in the cycle after the retire.
- R5: A CPU read is issued (`mem_en`=1, `mem_we`=0, `mem_addr`=`cpu_addr`) only in a cycle with `rfsh_req` low and no buffered write. `cpu_ready` stays low until the cycle after the issue.
- R6: A pending buffered write is retired before a following read is issued, so the read returns the newly written data.
- R7: Reset (asynchronous assertion, release synchronised over two clock edges) empties the buffer and the read state. After release, with no requests, `cpu_ready`=0 and `mem_en`=0.
- R8: Read completion raises `cpu_ready` for exactly one cycle. In that cycle `cpu_rdata` holds the memory data for the read address.
- R9: With `rfsh_req` low, no buffered write and no read to issue, `mem_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_ready | output | 1 | Write accepted, or read data valid |
| cpu_rdata | output | DW | Read data, valid while cpu_ready for a read |
| rfsh_req | input | 1 | Refresh requests the memory this cycle |
| rfsh_addr | input | AW | Refresh address |
| rfsh_grant | output | 1 | Refresh owns the memory this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |

## Verification
A buffer flag stuck at set shows up as a permanently stalled second write, and as a read that is never issued, in the cycle after the first capture. A flag stuck at clear shows up as a missing write strobe in the next free cycle. Both faults also give stale read-back data a few cycles later. A wrong read state shows up as a ready that lasts two cycles or comes one cycle early, with the wrong data on `cpu_rdata`. Loss of refresh priority shows up as a CPU address on `mem_addr` in a refresh cycle.

// File: rtl/pw_arb_pkg.sv
package pw_arb_pkg;
  typedef enum logic [0:0] {
    RD_IDLE = 1'b0,
    RD_DATA = 1'b1
  } rd_state_t;
endpackage

// File: rtl/pw_post_buf.sv
module pw_post_buf #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          retire,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  logic valid_d;

  always_comb begin
    valid_d = valid;
    if (retire) valid_d = 1'b0;
    if (load)   valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  // Payload registers: clock enable only, no reset needed.
  always_ff @(posedge clk) begin
    if (load) begin
      addr <= ld_addr;
      data <= ld_data;
    end
  end
endmodule

// File: rtl/pw_read_ctl.sv
module pw_read_ctl
  import pw_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic idle,
  output logic done
);
  rd_state_t state, state_d;

  always_comb begin
    state_d = state;
    case (state)
      RD_IDLE: if (issue) state_d = RD_DATA;
      RD_DATA: state_d = RD_IDLE;
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RD_IDLE;
    else        state <= state_d;
  end

  assign idle = (state == RD_IDLE);
  assign done = (state == RD_DATA);
endmodule

// File: rtl/pw_slot_mux.sv
module pw_slot_mux #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          rfsh_req,
  input  logic [AW-1:0] rfsh_addr,
  input  logic          buf_valid,
  input  logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] buf_data,
  input  logic          rd_want,
  input  logic [AW-1:0] rd_addr,
  output logic          grant,
  output logic          retire,
  output logic          rd_issue,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  // Fixed priority: refresh, then posted write, then CPU read.
  always_comb begin
    grant     = 1'b0;
    retire    = 1'b0;
    rd_issue  = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = rd_addr;
    mem_wdata = buf_data;
    if (rfsh_req) begin
      grant    = 1'b1;
      mem_en   = 1'b1;
      mem_addr = rfsh_addr;
    end else if (buf_valid) begin
      retire   = 1'b1;
      mem_en   = 1'b1;
      mem_we   = 1'b1;
      mem_addr = buf_addr;
    end else if (rd_want) begin
      rd_issue = 1'b1;
      mem_en   = 1'b1;
    end
  end
endmodule

// File: rtl/pw_mem_arbiter.sv
module pw_mem_arbiter #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  input  logic          rfsh_req,
  input  logic [AW-1:0] rfsh_addr,
  output logic          rfsh_grant,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  logic          buf_valid, buf_load, buf_retire;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_data;
  logic          rd_idle, rd_done, rd_issue, rd_want;

  assign buf_load = cpu_req & cpu_we & ~buf_valid;
  assign rd_want  = cpu_req & ~cpu_we & rd_idle;

  pw_post_buf #(.AW(AW), .DW(DW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (buf_load),
    .ld_addr (cpu_addr),
    .ld_data (cpu_wdata),
    .retire  (buf_retire),
    .valid   (buf_valid),
    .addr    (buf_addr),
    .data    (buf_data)
  );

  pw_read_ctl u_rd (
    .clk   (clk),
    .rst_n (rst_int_n),
    .issue (rd_issue),
    .idle  (rd_idle),
    .done  (rd_done)
  );

  pw_slot_mux #(.AW(AW), .DW(DW)) u_mux (
    .rfsh_req  (rfsh_req),
    .rfsh_addr (rfsh_addr),
    .buf_valid (buf_valid),
    .buf_addr  (buf_addr),
    .buf_data  (buf_data),
    .rd_want   (rd_want),
    .rd_addr   (cpu_addr),
    .grant     (rfsh_grant),
    .retire    (buf_retire),
    .rd_issue  (rd_issue),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign cpu_ready = buf_load | rd_done;
  assign cpu_rdata = mem_rdata;
endmodule

// File: rtl/pw_mem_arbiter_chk.sv
module pw_mem_arbiter_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_ready,
  input logic          rfsh_req,
  input logic [AW-1:0] rfsh_addr,
  input logic          rfsh_grant,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          buf_valid
);
  logic wr_acc, rd_acc, rd_issue;
  assign wr_acc   = cpu_req & cpu_we & cpu_ready;
  assign rd_acc   = cpu_req & ~cpu_we & cpu_ready;
  assign rd_issue = mem_en & ~mem_we & ~rfsh_req;

  p_rfsh_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |-> (rfsh_grant && mem_en && !mem_we && mem_addr == rfsh_addr));

  p_retire_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (rfsh_req || (mem_en && mem_we)));

  p_no_second_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !(cpu_we && cpu_ready));

  p_read_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> cpu_ready);

  p_write_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> !buf_valid);

  p_read_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc);
endmodule

bind pw_mem_arbiter pw_mem_arbiter_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_ready  (cpu_ready),
  .rfsh_req   (rfsh_req),
  .rfsh_addr  (rfsh_addr),
  .rfsh_grant (rfsh_grant),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .buf_valid  (buf_valid)
);

// File: tb/pw_mem_arbiter_bench.sv
module pw_mem_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [AW-1:0] RF_ADDR = 8'h80;

  typedef struct packed {
    logic          rf;
    logic          cq;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          e_rdy;
    logic          e_men;
    logic          e_mwe;
    logic [AW-1:0] e_maddr;
    logic          chk_rd;
    logic [DW-1:0] e_rdata;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,8'h10,8'h5A, 1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00}, // R2 accept
    '{1'b1,1'b1,1'b1,8'h11,8'h3C, 1'b0,1'b1,1'b0,RF_ADDR,1'b0,8'h00}, // R1 R4
    '{1'b0,1'b1,1'b1,8'h11,8'h3C, 1'b0,1'b1,1'b1,8'h10, 1'b0,8'h00}, // R3 R4
    '{1'b0,1'b1,1'b1,8'h11,8'h3C, 1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00}, // R4 accepted
    '{1'b0,1'b1,1'b0,8'h10,8'h00, 1'b0,1'b1,1'b1,8'h11, 1'b0,8'h00}, // R6 retire first
    '{1'b1,1'b1,1'b0,8'h10,8'h00, 1'b0,1'b1,1'b0,RF_ADDR,1'b0,8'h00}, // R1 R5
    '{1'b0,1'b1,1'b0,8'h10,8'h00, 1'b0,1'b1,1'b0,8'h10, 1'b0,8'h00}, // R5 issue
    '{1'b0,1'b1,1'b0,8'h10,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b1,8'h5A}, // R8 data
    '{1'b0,1'b0,1'b0,8'h00,8'h00, 1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00}, // R8 R9
    '{1'b1,1'b1,1'b0,8'h11,8'h00, 1'b0,1'b1,1'b0,RF_ADDR,1'b0,8'h00}, // R1
    '{1'b0,1'b1,1'b0,8'h11,8'h00, 1'b0,1'b1,1'b0,8'h11, 1'b0,8'h00}, // R5
    '{1'b1,1'b1,1'b0,8'h11,8'h00, 1'b1,1'b1,1'b0,RF_ADDR,1'b1,8'h3C}, // R8 R1
    '{1'b0,1'b1,1'b1,8'h12,8'hC3, 1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00}, // R2
    '{1'b0,1'b1,1'b1,8'h13,8'h99, 1'b0,1'b1,1'b1,8'h12, 1'b0,8'h00}, // R3 R4
    '{1'b0,1'b1,1'b1,8'h13,8'h99, 1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00}, // R4
    '{1'b0,1'b0,1'b0,8'h00,8'h00, 1'b0,1'b1,1'b1,8'h13, 1'b0,8'h00}, // R3
    '{1'b0,1'b1,1'b0,8'h13,8'h00, 1'b0,1'b1,1'b0,8'h13, 1'b0,8'h00}, // R5 R6
    '{1'b0,1'b1,1'b0,8'h13,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b1,8'h99}, // R8 R6
    '{1'b0,1'b0,1'b0,8'h00,8'h00, 1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00}  // R9
  };

  logic          clk, rst_n;
  logic          cpu_req, cpu_we, cpu_ready;
  logic [AW-1:0] cpu_addr, rfsh_addr, mem_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
  logic          rfsh_req, rfsh_grant, mem_en, mem_we;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic [DW-1:0] mem [1 << AW];

  pw_mem_arbiter #(.AW(AW), .DW(DW)) u_pw_mem_arbiter (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .rfsh_req(rfsh_req), .rfsh_addr(rfsh_addr), .rfsh_grant(rfsh_grant),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Synchronous memory model, one-cycle read latency.
  initial for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i) ^ 8'hA5;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rf, input logic cq, input logic we,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    rfsh_req = rf; cpu_req = cq; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rfsh_req = 1'b0; rfsh_addr = RF_ADDR;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R7 reset ready", 32'(cpu_ready), 0);
    chk("R7 reset mem_en", 32'(mem_en), 0);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].rf, VEC[k].cq, VEC[k].we, VEC[k].addr, VEC[k].wd);
      chk($sformatf("R4 R8 ready v%0d", k), 32'(cpu_ready), 32'(VEC[k].e_rdy));
      chk($sformatf("R1 grant v%0d", k), 32'(rfsh_grant), 32'(VEC[k].rf));
      chk($sformatf("R9 mem_en v%0d", k), 32'(mem_en), 32'(VEC[k].e_men));
      if (VEC[k].e_men) begin
        chk($sformatf("R3 R5 mem_we v%0d", k), 32'(mem_we), 32'(VEC[k].e_mwe));
        chk($sformatf("R3 R5 mem_addr v%0d", k), 32'(mem_addr), 32'(VEC[k].e_maddr));
      end
      if (VEC[k].chk_rd)
        chk($sformatf("R8 rdata v%0d", k), 32'(cpu_rdata), 32'(VEC[k].e_rdata));
    end

    // R1/R3: refresh held back-to-back keeps the write buffered.
    drive(1'b0, 1'b1, 1'b1, 8'h20, 8'h77);
    chk("R2 accept 20", 32'(cpu_ready), 1);
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
      chk("R1 refresh holds port", 32'(mem_we), 0);
    end
    drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    chk("R3 retire we", 32'(mem_we), 1);
    chk("R3 retire addr", 32'(mem_addr), 32'h20);
    chk("R3 retire data", 32'(mem_wdata), 32'h77);

    // R7: reset drops a pending write.
    drive(1'b0, 1'b1, 1'b1, 8'h30, 8'h44);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    rst_n = 1'b1;
    repeat (3) drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    chk("R7 buffer dropped", 32'(mem_en), 0);
    chk("R7 ready low", 32'(cpu_ready), 0);
    drive(1'b0, 1'b1, 1'b1, 8'h31, 8'h55);
    chk("R7 R2 accept after reset", 32'(cpu_ready), 1);
    drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    chk("R3 retire after reset", 32'(mem_addr), 32'h31);
    drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    chk("R7 location 30 untouched", 32'(mem[8'h30]), 32'(8'h30 ^ 8'hA5));

    finish_run();
  end
endmodule